// File: doc/BRIEF.md
# Address Phase Parity Error Reporter

This block watches the address phases of a shared PCI bus and checks each one for a parity error, whether or not the device is the target of that transaction. For every address phase it forms the even parity of the address/data lines and the command/byte-enable lines. It compares that parity with the PAR line, which it samples on the following clock. On a mismatch it sets sticky error flags in the status register. If two command-register enables are both on, it also pulses the system-error output for one clock.

When the corrupt address decoded to this device, the block also raises a one-clock indication to the target logic, telling it to keep the claim and finish the cycle as if the address were good. Software clears the status flags by writing ones to their bit positions. A dual-address cycle is seen as two address phases in a row, and each phase is checked and reported on its own.

Top module: `addr_par_guard`

## Requirements
- R1: An address phase is the first clock in which `frame_n` is low after a clock in which it was high. Every address phase is checked, whatever the value of `addr_hit`.
- R2: Parity is even. An error exists when the XOR of `ad`, `cbe_n` taken in the address phase and `par` taken on the next clock is 1. The outputs show the error after the rising edge that samples `par`.
- R3: If `cmd_serr_en` or `cmd_perr_resp` is low when an error is found, only `stat_dpe` (status bit 15) is set. `stat_sse` and `serr_oe` stay low.
- R4: If both enables are high when an error is found, `stat_sse` (bit 14) and `stat_dpe` are both set, and `serr_oe` is high for exactly one clock for that error.
- R5: `claim_keep` is high for one clock, aligned with the error report, only when the erroneous phase had `addr_hit` high.
- R6: The status bits are sticky. A cycle with `cfg_wr` high clears bit 15 if `cfg_wdata[15]` is 1 and bit 14 if `cfg_wdata[14]` is 1. Zeros in those positions, and all other data bits, have no effect.
- R7: If a new error and a clearing write fall in the same cycle, the error wins and the bits stay set.
- R8: If `cbe_n` is 4'b1101 in a first address phase, the next clock is a second address phase. Its parity is checked against `par` one clock later, independently of the first phase.
- R9: After reset, both status bits, `serr_oe` and `claim_keep` are low.
- R10: Data phases are not checked. Bad parity on data clocks sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Bus cycle framing, active low |
| ad | input | 32 | Multiplexed address/data lines |
| cbe_n | input | 4 | Command / byte enables |
| par | input | 1 | Even parity over the previous clock's `ad` and `cbe_n` |
| addr_hit | input | 1 | Target decode says the current address phase selects this device |
| cmd_serr_en | input | 1 | Command register system-error enable |
| cmd_perr_resp | input | 1 | Command register parity-error response enable |
| cfg_wr | input | 1 | Configuration write strobe to the status register |
| cfg_wdata | input | 16 | Status register write data (write-one-to-clear) |
| stat_dpe | output | 1 | Status bit 15: detected parity error |
| stat_sse | output | 1 | Status bit 14: signaled system error |
| serr_oe | output | 1 | Drive enable for the open-drain system-error line |
| claim_keep | output | 1 | Keep the claim on a cycle whose address was corrupt |

## Verification
A corrupted phase capture register would show two clocks after the address phase: a false or missing error on `stat_dpe`, with `serr_oe` and `claim_keep` tracking it in the same cycle. A stuck dual-address flag would show one clock later than that, as a missing report for the second phase or a spurious report on a data clock. A wrong sticky-bit state appears at the first clearing write or at the next error, because the flags must hold, clear or win against a write in exactly that cycle.

// File: rtl/apr_pkg.sv
package apr_pkg;

    // What the tracker says about the current clock
    typedef enum logic [1:0] {
        PH_NONE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_kind_e;

    // Captured address phase waiting for its parity bit
    typedef struct packed {
        logic valid;
        logic exp_par;
        logic hit;
    } addr_cap_t;

    // Sticky status flags
    typedef struct packed {
        logic dpe;
        logic sse;
    } err_stat_t;

    // Result of one parity comparison
    typedef struct packed {
        logic err;
        logic err_hit;
    } chk_res_t;

    function automatic logic par_mismatch(input logic expected, input logic seen);
        return expected ^ seen;
    endfunction

    function automatic logic is_phase(input phase_kind_e k);
        return k != PH_NONE;
    endfunction

endpackage

// File: rtl/apr_phase_tracker.sv
module apr_phase_tracker
    import apr_pkg::*;
#(
    parameter int unsigned CBE_W = 4,
    parameter logic [CBE_W-1:0] DUAL_CMD = 4'b1101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic [CBE_W-1:0] cbe_n,
    output phase_kind_e      kind
);
    logic frame_idle_q;   // frame_n was high on the previous clock
    logic dual_q;         // previous clock was a dual-address first phase

    always_comb begin
        kind = PH_NONE;
        if (!frame_n) begin
            if (frame_idle_q)
                kind = PH_FIRST;
            else if (dual_q)
                kind = PH_SECOND;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_idle_q <= 1'b1;
            dual_q       <= 1'b0;
        end else begin
            frame_idle_q <= frame_n;
            dual_q       <= (kind == PH_FIRST) && (cbe_n == DUAL_CMD);
        end
    end

    // R8: a second phase always follows a first one
    p_second_after_first_r8: assert property (@(posedge clk) disable iff (rst)
        (kind == PH_SECOND) |-> ($past(kind) == PH_FIRST));

endmodule

// File: rtl/apr_par_check.sv
module apr_par_check
    import apr_pkg::*;
#(
    parameter int unsigned AD_W  = 32,
    parameter int unsigned CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_valid,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe_n,
    input  logic             hit,
    input  logic             par,
    output chk_res_t         res
);
    addr_cap_t cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid   <= phase_valid;
            cap_q.exp_par <= ^{ad, cbe_n};
            cap_q.hit     <= hit;
        end
    end

    always_comb begin
        res.err     = cap_q.valid && par_mismatch(cap_q.exp_par, par);
        res.err_hit = res.err && cap_q.hit;
    end

    // R1: an error is only raised for a clock that followed an address phase
    p_err_after_phase_r1: assert property (@(posedge clk) disable iff (rst)
        res.err |-> $past(phase_valid));

endmodule

// File: rtl/apr_stat_regs.sv
module apr_stat_regs
    import apr_pkg::*;
#(
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned DPE_BIT = 15,
    parameter int unsigned SSE_BIT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              err,
    input  logic              sys_en,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    output err_stat_t         stat
);
    logic clr_dpe, clr_sse;

    assign clr_dpe = wr && wdata[DPE_BIT];
    assign clr_sse = wr && wdata[SSE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            // a new error outranks a clearing write (R7)
            if (err)
                stat.dpe <= 1'b1;
            else if (clr_dpe)
                stat.dpe <= 1'b0;

            if (err && sys_en)
                stat.sse <= 1'b1;
            else if (clr_sse)
                stat.sse <= 1'b0;
        end
    end

    // R6: flag holds unless a write of one to its position
    p_dpe_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat.dpe && !clr_dpe) |=> stat.dpe);
    p_sse_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat.sse && !clr_sse) |=> stat.sse);
    // R7: set wins over clear
    p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (err && clr_dpe) |=> stat.dpe);

endmodule

// File: rtl/apr_serr_gen.sv
module apr_serr_gen
    import apr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chk_res_t res,
    input  logic     sys_en,
    output logic     serr_oe,
    output logic     claim_keep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            serr_oe    <= 1'b0;
            claim_keep <= 1'b0;
        end else begin
            serr_oe    <= res.err && sys_en;
            claim_keep <= res.err_hit;
        end
    end

    // R4: a pulse is never stretched without a fresh error
    p_serr_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
        (serr_oe && !res.err) |=> !serr_oe);

endmodule

// File: rtl/addr_par_guard.sv
module addr_par_guard
    import apr_pkg::*;
#(
    parameter int unsigned AD_W    = 32,
    parameter int unsigned CBE_W   = 4,
    parameter int unsigned STAT_W  = 16,
    parameter int unsigned DPE_BIT = 15,
    parameter int unsigned SSE_BIT = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [AD_W-1:0]   ad,
    input  logic [CBE_W-1:0]  cbe_n,
    input  logic              par,
    input  logic              addr_hit,
    input  logic              cmd_serr_en,
    input  logic              cmd_perr_resp,
    input  logic              cfg_wr,
    input  logic [STAT_W-1:0] cfg_wdata,
    output logic              stat_dpe,
    output logic              stat_sse,
    output logic              serr_oe,
    output logic              claim_keep
);
    localparam logic [CBE_W-1:0] DUAL_CMD = CBE_W'(4'b1101);

    phase_kind_e kind;
    chk_res_t    res;
    err_stat_t   stat;
    logic        sys_en;

    assign sys_en = cmd_serr_en && cmd_perr_resp;

    apr_phase_tracker #(.CBE_W(CBE_W), .DUAL_CMD(DUAL_CMD)) u_track (
        .clk(clk), .rst(rst), .frame_n(frame_n), .cbe_n(cbe_n), .kind(kind)
    );

    apr_par_check #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
        .clk(clk), .rst(rst), .phase_valid(is_phase(kind)), .ad(ad),
        .cbe_n(cbe_n), .hit(addr_hit), .par(par), .res(res)
    );

    apr_stat_regs #(.STAT_W(STAT_W), .DPE_BIT(DPE_BIT), .SSE_BIT(SSE_BIT)) u_stat (
        .clk(clk), .rst(rst), .err(res.err), .sys_en(sys_en),
        .wr(cfg_wr), .wdata(cfg_wdata), .stat(stat)
    );

    apr_serr_gen u_serr (
        .clk(clk), .rst(rst), .res(res), .sys_en(sys_en),
        .serr_oe(serr_oe), .claim_keep(claim_keep)
    );

    assign stat_dpe = stat.dpe;
    assign stat_sse = stat.sse;

    // R4: system error pulse always lands with both flags set
    p_serr_sets_flags_r4: assert property (@(posedge clk) disable iff (rst)
        serr_oe |-> (stat_sse && stat_dpe));
    // R3: no system error pulse without both enables one clock earlier
    p_serr_needs_enables_r3: assert property (@(posedge clk) disable iff (rst)
        serr_oe |-> $past(cmd_serr_en && cmd_perr_resp));
    // R5: claim hold is only raised together with a detected error
    p_claim_with_error_r5: assert property (@(posedge clk) disable iff (rst)
        claim_keep |-> stat_dpe);

endmodule

// File: tb/addr_par_guard_test.sv
module addr_par_guard_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic        par, addr_hit, cmd_serr_en, cmd_perr_resp, cfg_wr;
    logic [15:0] cfg_wdata;
    logic        stat_dpe, stat_sse, serr_oe, claim_keep;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    addr_par_guard uut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
        .par(par), .addr_hit(addr_hit), .cmd_serr_en(cmd_serr_en),
        .cmd_perr_resp(cmd_perr_resp), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .stat_dpe(stat_dpe), .stat_sse(stat_sse), .serr_oe(serr_oe),
        .claim_keep(claim_keep)
    );

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic d, input logic s,
                           input logic o, input logic c);
        chk(req, "stat_dpe", stat_dpe, d);
        chk(req, "stat_sse", stat_sse, s);
        chk(req, "serr_oe", serr_oe, o);
        chk(req, "claim_keep", claim_keep, c);
    endtask

    task automatic clear_all();
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = 16'hC000;
        @(negedge clk); cfg_wr = 1'b0; cfg_wdata = 16'h0000;
        chk("R6", "cleared", stat_dpe | stat_sse, 1'b0);
    endtask

    // Single address phase, one data clock with deliberately bad data parity
    task automatic one_phase(input logic [31:0] a, input logic [3:0] c,
                             input logic bad, input logic h, input logic se, input logic pr);
        logic both;
        both = se & pr;
        cmd_serr_en = se; cmd_perr_resp = pr;
        @(negedge clk); frame_n = 1'b0; ad = a; cbe_n = c; addr_hit = h;
        @(negedge clk); frame_n = 1'b1; par = (^{a, c}) ^ bad;
        ad = ~a; cbe_n = 4'h0; addr_hit = 1'b0;
        @(negedge clk); par = ~(^{~a, 4'h0});   // R10: wrong data parity
        ad = 32'h0; cbe_n = 4'hF;
        chk_all("R2", bad, bad & both, bad & both, bad & h);
        @(negedge clk); par = 1'b0;
        chk_all("R4", bad, bad & both, 1'b0, 1'b0);
        @(negedge clk);
        chk_all("R10", bad, bad & both, 1'b0, 1'b0);
        if (bad) clear_all();
    endtask

    task automatic dual_phase(input logic [31:0] lo, input logic [31:0] hi,
                              input logic [3:0] c, input logic bad1, input logic bad2,
                              input logic h2);
        cmd_serr_en = 1'b1; cmd_perr_resp = 1'b1;
        @(negedge clk); frame_n = 1'b0; ad = lo; cbe_n = 4'b1101; addr_hit = 1'b0;
        @(negedge clk); ad = hi; cbe_n = c; addr_hit = h2;
        par = (^{lo, 4'b1101}) ^ bad1;
        @(negedge clk); frame_n = 1'b1; par = (^{hi, c}) ^ bad2;
        ad = 32'h0; cbe_n = 4'h0; addr_hit = 1'b0;
        chk("R8", "serr first", serr_oe, bad1);
        chk("R8", "claim first", claim_keep, 1'b0);
        @(negedge clk); par = 1'b1;
        chk("R8", "serr second", serr_oe, bad2);
        chk("R8", "claim second", claim_keep, bad2 & h2);
        chk("R8", "dpe", stat_dpe, bad1 | bad2);
        @(negedge clk);
        chk("R8", "serr idle", serr_oe, 1'b0);
        clear_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; frame_n = 1'b1; ad = '0; cbe_n = '0; par = 1'b0; addr_hit = 1'b0;
        cmd_serr_en = 1'b0; cmd_perr_resp = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_all("R9", 1'b0, 1'b0, 1'b0, 1'b0);

        // R1..R5, R10: sweep enables, hit, parity, address patterns
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 4; e++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int b = 0; b < 2; b++) begin
                        logic [31:0] a;
                        a = 32'h9E37_79B9 * (p + 1) ^ (32'h1 << (p * 4));
                        one_phase(a, 4'(p + 2), b[0], h[0], e[0], e[1]);
                    end
                end
            end
        end

        // R6: writing zeros in the flag positions leaves them set
        one_phase(32'h1234_5678, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1);
        // one_phase cleared; set again and hold
        cmd_serr_en = 1'b1; cmd_perr_resp = 1'b1;
        @(negedge clk); frame_n = 1'b0; ad = 32'hA5A5_0F0F; cbe_n = 4'h7;
        @(negedge clk); frame_n = 1'b1; par = ~(^{32'hA5A5_0F0F, 4'h7});
        @(negedge clk); par = 1'b0;
        cfg_wr = 1'b1; cfg_wdata = 16'h3FFF;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R6", "dpe after zero write", stat_dpe, 1'b1);
        chk("R6", "sse after zero write", stat_sse, 1'b1);
        cfg_wr = 1'b1; cfg_wdata = 16'h8000;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R6", "dpe cleared alone", stat_dpe, 1'b0);
        chk("R6", "sse kept", stat_sse, 1'b1);
        cfg_wr = 1'b1; cfg_wdata = 16'h4000;
        @(negedge clk); cfg_wr = 1'b0;
        chk("R6", "sse cleared", stat_sse, 1'b0);

        // R7: clear in the same cycle as a new error
        @(negedge clk); frame_n = 1'b0; ad = 32'h0000_00FF; cbe_n = 4'h2;
        @(negedge clk); frame_n = 1'b1; par = ~(^{32'h0000_00FF, 4'h2});
        cfg_wr = 1'b1; cfg_wdata = 16'hC000;
        @(negedge clk); cfg_wr = 1'b0; par = 1'b0;
        chk("R7", "dpe wins", stat_dpe, 1'b1);
        chk("R7", "sse wins", stat_sse, 1'b1);
        clear_all();

        // R8: dual-address cycles
        dual_phase(32'h1111_0000, 32'h0000_0001, 4'h6, 1'b1, 1'b0, 1'b1);
        dual_phase(32'h2222_0000, 32'h0000_0002, 4'h7, 1'b0, 1'b1, 1'b1);
        dual_phase(32'h3333_0000, 32'h0000_0003, 4'hC, 1'b1, 1'b1, 1'b0);
        dual_phase(32'h4444_0000, 32'h0000_0004, 4'h6, 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule